// File: doc/BRIEF.md
# Message-Interrupt Pending-Bit Updater

This block changes the pending state of a single message-signalled interrupt (IDs from 8192 upward) that belongs to one per-CPU interrupt router. A request carries an interrupt ID and a level. A level of 1 asks for the interrupt to be made pending. A level of 0 asks for it to be made not pending. Such requests come from an interrupt-generate command (level 1), from clear or discard commands (level 0), and from the CPU acknowledging the interrupt (level 0).

Both the per-interrupt configuration bytes and the pending bitmap live in system memory. The block reaches them through a byte-wide port that uses a valid/ready handshake and allows one access at a time.

For each request the block does the following:
- It checks the global settings. If they do not allow the request, the request is dropped.
- It reads the configuration byte and tests its enable bit.
- It reads the byte of the bitmap that holds the interrupt's bit.
- It writes that byte back only if the bit actually changes.
- It pulses a rescan request, which tells the highest-priority selector to throw away its cached winner, reset the cached priority to 0xFF and scan the table again.

Top module: `lpi_pend_engine`

## Requirements
- R1: After reset `busy`, `mem_valid` and `rescan_req` are all 0.
- R2: The first access for an accepted request is a byte read at `cfg_tbl_base + (ID - 8192)`.
- R3: If bit 0 of the configuration byte (the enable bit) is 0, the request ends after that read. No pending-table access is made and no rescan pulse is raised.
- R4: When the enable bit is set, the second access is a read of the byte at `pend_tbl_base + ID/8`. The interrupt's pending state is bit `ID mod 8` of that byte.
- R5: For a set request, the byte is written back to the same address, with only that bit changed, when the bit was 0. For a clear request, the same write-back happens when the bit was 1. If the bit already matches the level, no write is made.
- R6: A request is dropped with no memory access and no rescan pulse in any of these cases:
  - `lpi_en` is 0;
  - `cfg_tbl_base` is zero;
  - `pend_tbl_base` is zero;
  - the ID is below 8192.
- R7: The effective ID-bits value is the smaller of `id_bits_cfg` and the `DIST_IDBITS` parameter. If the effective value is below `IDBITS_MIN` (default 13), every request is dropped as in R6.
- R8: A request whose ID exceeds 2^(effective ID-bits + 1) is dropped as in R6. An ID exactly equal to that bound is processed.
- R9: Every request that reaches the pending-bitmap read raises `rescan_req` for exactly one cycle. This happens whether or not a write was needed, and only after the read and any write-back have completed.
- R10: Once `mem_valid` is raised, it stays high with `mem_addr`, `mem_write` and `mem_wdata` unchanged until the cycle in which `mem_ready` is high. Only one access is outstanding at a time.
- R11: While `busy` is high, `req_valid` is not accepted. A request held during processing causes no memory access of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Update request present; taken when `busy` is 0 |
| req_id | input | ID_W | Interrupt ID of the request |
| req_set | input | 1 | 1 = make pending, 0 = make not pending |
| busy | output | 1 | An accepted request is being processed |
| lpi_en | input | 1 | Global enable for message interrupts |
| cfg_tbl_base | input | ADDR_W | Byte address of the configuration table |
| pend_tbl_base | input | ADDR_W | Byte address of the pending bitmap |
| id_bits_cfg | input | 5 | Programmed ID-bits field |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_ready | input | 1 | Access completes in this cycle; read data is valid |
| mem_rdata | input | 8 | Read data |
| rescan_req | output | 1 | One-cycle request to invalidate the cached winner and rescan |

## Verification
A request is taken at the clock edge where `req_valid` is high and `busy` is 0. The configuration read appears on the port in the next cycle. Each following access appears in the cycle after the previous handshake, and `rescan_req` is high in the cycle after the last handshake. `busy` falls one cycle after that pulse, or one cycle after the configuration handshake when the enable bit is 0.

The bench's memory model answers on the falling edge with a varying number of wait cycles and logs every handshake. The bench then waits, sampling on falling edges, until `busy` is low again. Only after that does it compare the logged accesses, the count of rescan pulses and the model's bitmap byte against values it computed from the ID, the level and the configuration.

// File: rtl/lpi_pend_pkg.sv
package lpi_pend_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG_RD,
    ST_PEND_RD,
    ST_PEND_WR,
    ST_RESCAN
  } eng_state_e;

  // smaller of the programmed and the supported ID-bit counts
  function automatic logic [4:0] clip_idbits(input logic [4:0] prog,
                                             input logic [4:0] dist_max);
    return (prog < dist_max) ? prog : dist_max;
  endfunction

  // id may not exceed 2^(eff+1); equality is allowed
  function automatic logic id_under_ceiling(input logic [31:0] id,
                                            input logic [4:0]  eff);
    logic [63:0] ceil;
    ceil = 64'd1 << ({1'b0, eff} + 6'd1);
    return {32'd0, id} <= ceil;
  endfunction

  function automatic logic needs_write(input logic [7:0] b,
                                       input logic [2:0] pos,
                                       input logic       lvl);
    return b[pos] != lvl;
  endfunction

  function automatic logic [7:0] flip_bit(input logic [7:0] b,
                                          input logic [2:0] pos);
    return b ^ (8'd1 << pos);
  endfunction

endpackage

// File: rtl/lpi_req_gate.sv
module lpi_req_gate
  import lpi_pend_pkg::*;
#(
  parameter int unsigned ID_W        = 16,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned FIRST_ID    = 8192,
  parameter int unsigned DIST_IDBITS = 16,
  parameter int unsigned IDBITS_MIN  = 13
) (
  input  logic [ID_W-1:0]   req_id,
  input  logic              lpi_en,
  input  logic [ADDR_W-1:0] cfg_tbl_base,
  input  logic [ADDR_W-1:0] pend_tbl_base,
  input  logic [4:0]        id_bits_cfg,
  output logic              req_ok,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [2:0]        bit_pos
);
  localparam logic [4:0]  DIST_L  = 5'(DIST_IDBITS);
  localparam logic [4:0]  MIN_L   = 5'(IDBITS_MIN);
  localparam logic [31:0] FIRST_L = 32'(FIRST_ID);

  logic [31:0] id32;
  logic [4:0]  eff_bits;

  always_comb begin
    id32     = 32'(req_id);
    eff_bits = clip_idbits(id_bits_cfg, DIST_L);
    req_ok   = lpi_en
            && (cfg_tbl_base  != '0)
            && (pend_tbl_base != '0)
            && (eff_bits >= MIN_L)
            && (id32 >= FIRST_L)
            && id_under_ceiling(id32, eff_bits);
    cfg_addr  = cfg_tbl_base  + ADDR_W'(id32 - FIRST_L);
    pend_addr = pend_tbl_base + ADDR_W'(id32 >> 3);
    bit_pos   = req_id[2:0];
  end
endmodule

// File: rtl/lpi_rmw_fsm.sv
module lpi_rmw_fsm
  import lpi_pend_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_set,
  input  logic [ADDR_W-1:0] start_cfg_addr,
  input  logic [ADDR_W-1:0] start_pend_addr,
  input  logic [2:0]        start_bit,
  output logic              busy,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ready,
  input  logic [7:0]        mem_rdata,
  output logic              rescan_req
);
  eng_state_e        state, nxt;
  logic              set_q;
  logic [2:0]        bit_q;
  logic [ADDR_W-1:0] cfg_addr_q, pend_addr_q;
  logic [7:0]        wbyte_q;

  // named events for the checks
  logic xfer, cfg_xfer, pend_rd_xfer, pend_wr_xfer;

  always_comb begin
    xfer         = mem_valid && mem_ready;
    cfg_xfer     = xfer && (state == ST_CFG_RD);
    pend_rd_xfer = xfer && (state == ST_PEND_RD);
    pend_wr_xfer = xfer && (state == ST_PEND_WR);
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (start) nxt = ST_CFG_RD;
      ST_CFG_RD:  if (xfer) nxt = mem_rdata[0] ? ST_PEND_RD : ST_IDLE;
      ST_PEND_RD: if (xfer) nxt = needs_write(mem_rdata, bit_q, set_q)
                                  ? ST_PEND_WR : ST_RESCAN;
      ST_PEND_WR: if (xfer) nxt = ST_RESCAN;
      ST_RESCAN:  nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      set_q       <= 1'b0;
      bit_q       <= '0;
      cfg_addr_q  <= '0;
      pend_addr_q <= '0;
      wbyte_q     <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start) begin
        set_q       <= start_set;
        bit_q       <= start_bit;
        cfg_addr_q  <= start_cfg_addr;
        pend_addr_q <= start_pend_addr;
      end
      if (pend_rd_xfer) wbyte_q <= flip_bit(mem_rdata, bit_q);
    end
  end

  always_comb begin
    busy       = (state != ST_IDLE);
    mem_valid  = (state == ST_CFG_RD) || (state == ST_PEND_RD) || (state == ST_PEND_WR);
    mem_write  = (state == ST_PEND_WR);
    mem_addr   = (state == ST_CFG_RD) ? cfg_addr_q : pend_addr_q;
    mem_wdata  = wbyte_q;
    rescan_req = (state == ST_RESCAN);
  end

  // R10: request held steady until accepted
  assert_hold_until_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_write) && $stable(mem_wdata)));

  // R3: disabled configuration ends the request silently
  assert_cfg_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_xfer && !mem_rdata[0]) |=> (!mem_valid && !rescan_req));

  // R5: bit already at the requested level means no write-back
  assert_no_needless_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rd_xfer && (mem_rdata[bit_q] == set_q)) |=> (!mem_write && rescan_req));

  // R5: write-back is followed by the rescan pulse
  assert_write_then_rescan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr_xfer |=> rescan_req);

  // R9: rescan is a single-cycle pulse
  assert_rescan_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rescan_req |=> !rescan_req);
endmodule

// File: rtl/lpi_pend_engine.sv
module lpi_pend_engine
  import lpi_pend_pkg::*;
#(
  parameter int unsigned ID_W        = 16,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned FIRST_ID    = 8192,
  parameter int unsigned DIST_IDBITS = 16,
  parameter int unsigned IDBITS_MIN  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_set,
  output logic              busy,
  input  logic              lpi_en,
  input  logic [ADDR_W-1:0] cfg_tbl_base,
  input  logic [ADDR_W-1:0] pend_tbl_base,
  input  logic [4:0]        id_bits_cfg,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ready,
  input  logic [7:0]        mem_rdata,
  output logic              rescan_req
);
  logic              req_ok;
  logic [ADDR_W-1:0] cfg_addr, pend_addr;
  logic [2:0]        bit_pos;
  logic              start;

  lpi_req_gate #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .FIRST_ID(FIRST_ID),
    .DIST_IDBITS(DIST_IDBITS), .IDBITS_MIN(IDBITS_MIN)
  ) u_gate (
    .req_id(req_id), .lpi_en(lpi_en), .cfg_tbl_base(cfg_tbl_base),
    .pend_tbl_base(pend_tbl_base), .id_bits_cfg(id_bits_cfg),
    .req_ok(req_ok), .cfg_addr(cfg_addr), .pend_addr(pend_addr), .bit_pos(bit_pos)
  );

  assign start = req_valid && !busy && req_ok;

  lpi_rmw_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_set(req_set),
    .start_cfg_addr(cfg_addr), .start_pend_addr(pend_addr), .start_bit(bit_pos),
    .busy(busy), .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rescan_req(rescan_req)
  );

  // R6 / R7 / R8: a rejected request leaves the engine idle
  assert_ignored_stays_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !req_ok) |=> (!busy && !mem_valid));

  // R2: first access after acceptance is a read
  assert_first_is_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mem_valid && !mem_write));
endmodule

// File: tb/tb_lpi_pend_engine.sv
module tb_lpi_pend_engine;
  localparam int ID_W = 16;
  localparam int ADDR_W = 20;
  localparam int DISTB = 14;
  localparam int MINB = 13;
  localparam int FIRST = 8192;
  localparam logic [ADDR_W-1:0] CBASE = 20'h20000;
  localparam logic [ADDR_W-1:0] PBASE = 20'h08000;
  localparam int PSZ = 4104;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n, req_valid, req_set, busy, lpi_en;
  logic [ID_W-1:0] req_id;
  logic [ADDR_W-1:0] cfg_tbl_base, pend_tbl_base, mem_addr;
  logic [4:0] id_bits_cfg;
  logic mem_valid, mem_write, mem_ready, rescan_req;
  logic [7:0] mem_wdata, mem_rdata;

  lpi_pend_engine #(.ID_W(ID_W), .ADDR_W(ADDR_W), .FIRST_ID(FIRST),
                    .DIST_IDBITS(DISTB), .IDBITS_MIN(MINB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_set(req_set), .busy(busy), .lpi_en(lpi_en), .cfg_tbl_base(cfg_tbl_base),
    .pend_tbl_base(pend_tbl_base), .id_bits_cfg(id_bits_cfg),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rescan_req(rescan_req)
  );

  int vectors = 0, errors = 0;
  logic [7:0] pend_mem [PSZ];
  int acc_n, wait_cfg, wcnt;
  logic [ADDR_W-1:0] acc_addr [8];
  logic acc_wr [8];
  logic [7:0] acc_wd [8];

  function automatic logic [7:0] cfg_byte(input int id);
    return 8'((id * 37) & 8'hFE) | 8'((id % 7) != 5);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_ready = 1'b0; mem_rdata = 8'h00; wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_valid) begin
        if (wcnt >= wait_cfg) begin
          wcnt = 0;
          if (acc_n < 8) begin
            acc_addr[acc_n] = mem_addr; acc_wr[acc_n] = mem_write; acc_wd[acc_n] = mem_wdata;
          end
          acc_n++;
          if (mem_addr >= PBASE && mem_addr < PBASE + PSZ) begin
            if (mem_write) pend_mem[mem_addr - PBASE] = mem_wdata;
            else mem_rdata = pend_mem[mem_addr - PBASE];
          end else if (mem_addr >= CBASE)
            mem_rdata = cfg_byte(int'(mem_addr - CBASE) + FIRST);
          else mem_rdata = 8'h00;
          mem_ready = 1'b1;
        end else wcnt++;
      end
    end
  end

  task automatic do_req(input int id, input bit lvl, input bit intr, input string tag);
    int eff, ceil, exp_n, resc, pidx, bpos;
    bit ok, en, chg;
    logic [7:0] old_b, exp_b;
    eff = (int'(id_bits_cfg) < DISTB) ? int'(id_bits_cfg) : DISTB;
    ceil = 1 << (eff + 1);
    ok = lpi_en && cfg_tbl_base != 0 && pend_tbl_base != 0 && eff >= MINB
         && id >= FIRST && id <= ceil;
    en = cfg_byte(id) & 8'h01;
    pidx = id / 8; bpos = id % 8;
    old_b = pend_mem[pidx];
    chg = ok && en && (old_b[bpos] != lvl);
    exp_b = chg ? (old_b ^ (8'd1 << bpos)) : old_b;
    exp_n = !ok ? 0 : (!en ? 1 : (chg ? 3 : 2));
    acc_n = 0; resc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_id = ID_W'(id); req_set = lvl;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (!intr) req_valid = 1'b0;
      else req_id = ID_W'(id + 100);
      if (rescan_req) begin resc++; req_valid = 1'b0; end
      if (!busy) break;
    end
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(acc_n == exp_n, $sformatf("%s access count id=%0d", tag, id), acc_n, exp_n);
    if (exp_n >= 1 && acc_n >= 1)
      chk(acc_addr[0] == CBASE + ADDR_W'(id - FIRST) && !acc_wr[0],
          "R2 config read address", int'(acc_addr[0]), int'(CBASE) + id - FIRST);
    if (exp_n >= 2 && acc_n >= 2)
      chk(acc_addr[1] == PBASE + ADDR_W'(pidx) && !acc_wr[1],
          "R4 pending read address", int'(acc_addr[1]), int'(PBASE) + pidx);
    if (exp_n == 3 && acc_n >= 3)
      chk(acc_addr[2] == PBASE + ADDR_W'(pidx) && acc_wr[2] && acc_wd[2] == exp_b,
          "R5 write-back byte", int'(acc_wd[2]), int'(exp_b));
    chk(pend_mem[pidx] == exp_b, "R5 bitmap byte after update", int'(pend_mem[pidx]), int'(exp_b));
    chk(resc == ((exp_n >= 2) ? 1 : 0), $sformatf("R9 rescan pulses (%s)", exp_n == 1 ? "R3" : "R9"),
        resc, (exp_n >= 2) ? 1 : 0);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_set = 1'b0;
    lpi_en = 1'b1; cfg_tbl_base = CBASE; pend_tbl_base = PBASE; id_bits_cfg = 5'd13;
    wait_cfg = 0; acc_n = 0;
    for (int i = 0; i < PSZ; i++) pend_mem[i] = 8'(i * 29 + 7);
    repeat (4) @(negedge clk);
    chk(!busy && !mem_valid && !rescan_req, "R1 reset outputs",
        {busy, mem_valid, rescan_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_valid && !rescan_req, "R1 idle after reset",
        {busy, mem_valid, rescan_req}, 0);

    for (int id = 8192; id < 8448; id++) begin wait_cfg = id % 3; do_req(id, 1'b1, 1'b0, "R5 set"); end
    for (int id = 8192; id < 8448; id++) begin wait_cfg = (id / 3) % 3; do_req(id, 1'b0, 1'b0, "R5 clear"); end
    for (int id = 8192; id < 8320; id++) begin wait_cfg = 1; do_req(id, 1'b0, 1'b0, "R5 clear again"); end
    wait_cfg = 0;

    do_req(16384, 1'b1, 1'b0, "R8 id at bound");
    do_req(16385, 1'b1, 1'b0, "R8 id over bound");
    do_req(8191, 1'b1, 1'b0, "R6 id below range");
    id_bits_cfg = 5'd12; do_req(9000, 1'b1, 1'b0, "R7 below threshold");
    id_bits_cfg = 5'd20; do_req(32768, 1'b1, 1'b0, "R7 clipped bound");
    do_req(32769, 1'b1, 1'b0, "R7 over clipped bound");
    id_bits_cfg = 5'd13; do_req(20000, 1'b1, 1'b0, "R7 programmed bound");
    lpi_en = 1'b0; do_req(8200, 1'b1, 1'b0, "R6 disabled"); lpi_en = 1'b1;
    cfg_tbl_base = '0; do_req(8200, 1'b1, 1'b0, "R6 config base zero"); cfg_tbl_base = CBASE;
    pend_tbl_base = '0; do_req(8200, 1'b1, 1'b0, "R6 pending base zero"); pend_tbl_base = PBASE;

    wait_cfg = 2;
    do_req(8200, 1'b1, 1'b1, "R11 held request while busy");
    do_req(8201, 1'b0, 1'b1, "R11 held request while busy");
    wait_cfg = 0;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule